// File: doc/BRIEF.md
# Intra-Row Rotating Wear Leveler

This block sits between a host memory port and a wear-limited memory array whose rows are written as whole words. Each row's data is stored rotated by a whole number of bytes. The rotation amount for each row is held in a small per-row table. Every host write is turned into a read of the old stored row followed by a masked write. The mask marks only the bits that actually change, so unchanged cells are never reprogrammed. The rotation is applied before that comparison, so bits that are rewritten often get moved across the row over time.

Each row also has a write counter. When a row has taken the configured number of writes, the block starts a migration. It reads the row back, rotates the stored image one more byte, writes it back with a change mask, and then steps that row's rotation amount by one. The amount wraps modulo the row width in bytes. While a read, a masked write or a migration is in progress the host port is not ready. Reads are rotated back, so the host only ever sees the data it wrote.

The array is assumed to return read data one clock after a read request and to hold it until the next read. It applies a write only to the bits whose mask bit is 1.

Top module: `row_rotate_leveler`

## Requirements
- R1: After reset h_ready is 1, h_rvalid is 0, a_req is 0, and every row's rotation amount and write count are 0. A first write to any row is therefore stored unrotated.
- R2: A write accepted in cycle T (h_req and h_ready and h_we) issues an array read of that row in T. In T+1 it issues an array write of the same row. Logical byte i (bits 8i+7..8i) of h_wdata is placed at stored byte (i + offset) mod ROW_BYTES.
- R3: During every array write, a_wmask bit k is 1 exactly when the new stored bit k differs from the row's current stored bit k.
- R4: A read accepted in cycle T issues an array read in T. In T+1 h_rvalid is 1, h_ready is 0, and h_rdata holds the stored data with stored byte (i + offset) mod ROW_BYTES returned as logical byte i. At all other times h_rvalid is 0.
- R5: Each row counts its own writes. The WR_INTERVAL-th write to a row since reset or since its last migration starts a migration. Writes to other rows leave that count unchanged, and any other write returns h_ready to 1 in T+2.
- R6: A migration follows the triggering write. The row is read in T+2 and rewritten in T+3 with its stored image rotated one more byte toward higher byte positions, under a change mask. From T+4 the row's offset is one larger. h_ready is 0 from T+1 through T+3.
- R7: The offset wraps modulo ROW_BYTES. After ROW_BYTES migrations a row is stored unrotated again.
- R8: A read always returns the last data written to that row, across any number of migrations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host request, taken when h_ready is 1 |
| h_we | input | 1 | Host request is a write |
| h_addr | input | AW | Host row address |
| h_wdata | input | ROW_BYTES*8 | Host write data, logical order |
| h_ready | output | 1 | Block can take a request this cycle |
| h_rvalid | output | 1 | h_rdata holds read data |
| h_rdata | output | ROW_BYTES*8 | Read data in logical order, 0 when not valid |
| a_req | output | 1 | Array access this cycle |
| a_we | output | 1 | Array access is a write |
| a_addr | output | AW | Array row address |
| a_wdata | output | ROW_BYTES*8 | Array write data, rotated |
| a_wmask | output | ROW_BYTES*8 | Per-bit write enable for the array |
| a_rdata | input | ROW_BYTES*8 | Array read data, valid the cycle after a read |

## Verification
The writes use byte-distinct words, single walking bits, and repeats of the stored value. The distinct bytes reveal a wrong rotation direction or amount. The walking bits show whether the change mask follows the stored image rather than the logical one, and a repeated value must produce an all-zero mask. One row is hammered through four full intervals while a second row gets sparse writes. This separates per-row counting from a shared counter, checks each migration's rotate-by-one image, and shows the offset wrapping back to unrotated storage. Interleaved read-backs after every migration confirm that the host view never changes.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DATA,
    ST_WR_CMP,
    ST_MIG_RD,
    ST_MIG_WR
  } wl_state_e;
endpackage

// File: rtl/wl_byte_rotator.sv
module wl_byte_rotator #(
  parameter int NB   = 8,
  parameter int AMTW = 3,
  parameter bit LEFT = 1'b1
) (
  input  logic [NB*8-1:0] din,
  input  logic [AMTW-1:0] amt,
  output logic [NB*8-1:0] dout
);
  // LEFT: input byte i lands on output byte (i+amt) mod NB; otherwise the inverse.
  always_comb begin
    for (int j = 0; j < NB; j++) begin
      int src;
      if (LEFT) src = (j + NB - int'(amt)) % NB;
      else      src = (j + int'(amt)) % NB;
      dout[j*8 +: 8] = din[src*8 +: 8];
    end
  end
endmodule

// File: rtl/wl_row_table.sv
module wl_row_table #(
  parameter int ROWS        = 16,
  parameter int ROW_BYTES   = 8,
  parameter int WR_INTERVAL = 256,
  parameter int AW          = 4,
  parameter int OFFW        = 3,
  parameter int CNTW        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   sel_row,
  input  logic            bump_cnt,
  input  logic            advance_off,
  output logic [OFFW-1:0] cur_off,
  output logic            at_limit
);
  logic [OFFW-1:0] off_q [ROWS];
  logic [CNTW-1:0] cnt_q [ROWS];

  function automatic logic [OFFW-1:0] step_off(input logic [OFFW-1:0] o);
    if (int'(o) == ROW_BYTES - 1) return '0;
    return o + OFFW'(1);
  endfunction

  assign cur_off  = off_q[sel_row];
  assign at_limit = (cnt_q[sel_row] == CNTW'(WR_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        off_q[r] <= '0;
        cnt_q[r] <= '0;
      end
    end else begin
      if (bump_cnt)
        cnt_q[sel_row] <= at_limit ? '0 : cnt_q[sel_row] + CNTW'(1);
      if (advance_off)
        off_q[sel_row] <= step_off(off_q[sel_row]);
    end
  end
endmodule

// File: rtl/row_rotate_leveler.sv
module row_rotate_leveler #(
  parameter int ROWS        = 16,
  parameter int ROW_BYTES   = 8,
  parameter int WR_INTERVAL = 256,
  localparam int W    = ROW_BYTES * 8,
  localparam int AW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int OFFW = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1,
  localparam int CNTW = (WR_INTERVAL > 1) ? $clog2(WR_INTERVAL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [W-1:0]  h_wdata,
  output logic          h_ready,
  output logic          h_rvalid,
  output logic [W-1:0]  h_rdata,
  output logic          a_req,
  output logic          a_we,
  output logic [AW-1:0] a_addr,
  output logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_wmask,
  input  logic [W-1:0]  a_rdata
);
  import wl_pkg::*;

  wl_state_e       state_q, state_d;
  logic [AW-1:0]   row_q;
  logic [W-1:0]    data_q;
  logic [AW-1:0]   sel_row;
  logic [OFFW-1:0] cur_off;
  logic            at_limit;
  logic [W-1:0]    wr_img, rd_img, mig_img;

  // named internal events for the checker
  logic accept, ev_wr_commit, ev_mig_start, ev_off_advance;

  assign h_ready        = (state_q == ST_IDLE);
  assign accept         = h_req && h_ready;
  assign ev_wr_commit   = (state_q == ST_WR_CMP);
  assign ev_mig_start   = ev_wr_commit && at_limit;
  assign ev_off_advance = (state_q == ST_MIG_WR);
  assign sel_row        = (state_q == ST_IDLE) ? h_addr : row_q;

  wl_row_table #(
    .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .WR_INTERVAL(WR_INTERVAL),
    .AW(AW), .OFFW(OFFW), .CNTW(CNTW)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .sel_row(sel_row),
    .bump_cnt(ev_wr_commit), .advance_off(ev_off_advance),
    .cur_off(cur_off), .at_limit(at_limit)
  );

  wl_byte_rotator #(.NB(ROW_BYTES), .AMTW(OFFW), .LEFT(1'b1)) u_rot_wr (
    .din(data_q), .amt(cur_off), .dout(wr_img));
  wl_byte_rotator #(.NB(ROW_BYTES), .AMTW(OFFW), .LEFT(1'b0)) u_rot_rd (
    .din(a_rdata), .amt(cur_off), .dout(rd_img));
  wl_byte_rotator #(.NB(ROW_BYTES), .AMTW(OFFW), .LEFT(1'b1)) u_rot_mig (
    .din(a_rdata), .amt(OFFW'(1 % ROW_BYTES)), .dout(mig_img));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = h_we ? ST_WR_CMP : ST_RD_DATA;
      ST_RD_DATA: state_d = ST_IDLE;
      ST_WR_CMP:  state_d = at_limit ? ST_MIG_RD : ST_IDLE;
      ST_MIG_RD:  state_d = ST_MIG_WR;
      ST_MIG_WR:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        row_q  <= h_addr;
        data_q <= h_wdata;
      end
    end
  end

  always_comb begin
    a_req    = 1'b0;
    a_we     = 1'b0;
    a_addr   = row_q;
    a_wdata  = '0;
    a_wmask  = '0;
    h_rvalid = 1'b0;
    h_rdata  = '0;
    unique case (state_q)
      ST_IDLE: begin
        a_req  = accept;
        a_addr = h_addr;
      end
      ST_RD_DATA: begin
        h_rvalid = 1'b1;
        h_rdata  = rd_img;
      end
      ST_WR_CMP: begin
        a_req   = 1'b1;
        a_we    = 1'b1;
        a_wdata = wr_img;
        a_wmask = wr_img ^ a_rdata;
      end
      ST_MIG_RD: a_req = 1'b1;
      ST_MIG_WR: begin
        a_req   = 1'b1;
        a_we    = 1'b1;
        a_wdata = mig_img;
        a_wmask = mig_img ^ a_rdata;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wl_checker.sv
module wl_checker #(
  parameter int AW = 4,
  parameter int W  = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req,
  input logic          h_we,
  input logic          h_ready,
  input logic          h_rvalid,
  input logic [AW-1:0] h_addr,
  input logic          a_req,
  input logic          a_we,
  input logic [AW-1:0] a_addr,
  input logic [W-1:0]  a_wdata,
  input logic [W-1:0]  a_wmask,
  input logic [W-1:0]  a_rdata,
  input logic          ev_mig_start,
  input logic          ev_off_advance
);
  a_r1_ready_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({h_ready, h_rvalid}));

  a_r2_write_reads_first: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_ready && h_we) |-> (a_req && !a_we && a_addr == h_addr));

  a_r2_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_ready && h_we) |=> (a_req && a_we && a_addr == $past(h_addr)));

  a_r3_mask_no_redundant: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && a_we) |-> ((a_wmask & ~(a_wdata ^ a_rdata)) == '0));

  a_r4_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && h_ready && !h_we) |=> (h_rvalid && !h_ready));

  a_r6_mig_reads_row: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mig_start |=> (a_req && !a_we && a_addr == $past(a_addr) && !h_ready));

  a_r6_mig_writes_row: assert property (@(posedge clk) disable iff (!rst_n)
    ev_off_advance |-> (a_req && a_we && !h_ready));
endmodule

bind row_rotate_leveler wl_checker #(.AW(AW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_ready(h_ready),
  .h_rvalid(h_rvalid), .h_addr(h_addr), .a_req(a_req), .a_we(a_we),
  .a_addr(a_addr), .a_wdata(a_wdata), .a_wmask(a_wmask), .a_rdata(a_rdata),
  .ev_mig_start(ev_mig_start), .ev_off_advance(ev_off_advance)
);

// File: tb/sim_row_rotate_leveler.sv
`timescale 1ns/1ps
module sim_row_rotate_leveler;
  localparam int ROWS = 4, NB = 4, IVL = 256;
  localparam int W = NB * 8, AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_req = 1'b0, h_we = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [W-1:0]  h_wdata = '0;
  logic h_ready, h_rvalid, a_req, a_we;
  logic [W-1:0] h_rdata, a_wdata, a_wmask;
  logic [AW-1:0] a_addr;
  logic [W-1:0] a_rdata = '0;

  always #5 clk = ~clk;

  row_rotate_leveler #(.ROWS(ROWS), .ROW_BYTES(NB), .WR_INTERVAL(IVL)) u0 (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_ready(h_ready), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_wmask(a_wmask), .a_rdata(a_rdata));

  // array model: read data one clock later, per-bit masked writes
  logic [W-1:0] arr [ROWS];
  initial for (int r = 0; r < ROWS; r++) arr[r] = '0;
  always @(posedge clk) begin
    if (a_req && !a_we) a_rdata <= arr[a_addr];
    if (a_req && a_we)  arr[a_addr] <= (arr[a_addr] & ~a_wmask) | (a_wdata & a_wmask);
  end

  // reference model
  int ref_off [ROWS];
  int ref_cnt [ROWS];
  logic [W-1:0] ref_val [ROWS];
  logic [W-1:0] last_wdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] place(input logic [W-1:0] d, input int off);
    logic [W-1:0] r;
    for (int i = 0; i < NB; i++) r[((i + off) % NB)*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_write(input int r, input logic [W-1:0] d);
    logic [W-1:0] img, mimg;
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b1; h_addr = AW'(r); h_wdata = d;
    #1;
    chk(h_ready, "R2 ready at accept", W'(h_ready), 1);
    chk(a_req && !a_we && a_addr == AW'(r), "R2 read of old row", W'({a_req, a_we, a_addr}), W'({2'b10, AW'(r)}));
    img = place(d, ref_off[r]);
    mimg = img ^ arr[r];
    @(negedge clk);
    h_req = 1'b0; #1;
    chk(a_req && a_we && a_addr == AW'(r), "R2 masked write issued", W'({a_req, a_we, a_addr}), W'({2'b11, AW'(r)}));
    chk(a_wdata == img, "R2 rotated store image", a_wdata, img);
    chk(a_wmask == mimg, "R3 change mask", a_wmask, mimg);
    chk(!h_ready, "R5 busy during write", W'(h_ready), 0);
    last_wdata = a_wdata;
    ref_val[r] = d;
    ref_cnt[r]++;
    if (ref_cnt[r] == IVL) begin
      ref_cnt[r] = 0;
      @(negedge clk); #1;
      chk(a_req && !a_we && a_addr == AW'(r) && !h_ready, "R6 migration read",
          W'({a_req, a_we, h_ready, a_addr}), W'({3'b100, AW'(r)}));
      @(negedge clk); #1;
      chk(a_req && a_we && !h_ready, "R6 migration write", W'({a_req, a_we, h_ready}), W'(3'b110));
      chk(a_wdata == place(img, 1), "R6 rotate by one byte", a_wdata, place(img, 1));
      chk(a_wmask == (place(img, 1) ^ img), "R3 migration mask", a_wmask, place(img, 1) ^ img);
      ref_off[r] = (ref_off[r] + 1) % NB;
      @(negedge clk); #1;
      chk(h_ready, "R6 ready after migration", W'(h_ready), 1);
      chk(arr[r] == place(d, ref_off[r]), "R6 array holds new layout", arr[r], place(d, ref_off[r]));
    end else begin
      @(negedge clk); #1;
      chk(h_ready, "R5 no migration before interval", W'(h_ready), 1);
    end
  endtask

  task automatic do_read(input int r, input string tag);
    @(negedge clk);
    h_req = 1'b1; h_we = 1'b0; h_addr = AW'(r);
    #1;
    chk(a_req && !a_we && a_addr == AW'(r), "R4 array read issued", W'({a_req, a_we, a_addr}), W'({2'b10, AW'(r)}));
    @(negedge clk);
    h_req = 1'b0; #1;
    chk(h_rvalid && !h_ready, "R4 rvalid one cycle later", W'({h_rvalid, h_ready}), W'(2'b10));
    chk(h_rdata == ref_val[r], tag, h_rdata, ref_val[r]);
    @(negedge clk); #1;
    chk(h_ready && !h_rvalid, "R4 back to idle", W'({h_ready, h_rvalid}), W'(2'b10));
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      ref_off[r] = 0; ref_cnt[r] = 0; ref_val[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(h_ready && !h_rvalid && !a_req, "R1 reset outputs", W'({h_ready, h_rvalid, a_req}), W'(3'b100));
    do_read(2, "R4 read of untouched row");
    do_write(0, 32'h1122_3344);
    chk(last_wdata == 32'h1122_3344, "R1 first write unrotated", last_wdata, 32'h1122_3344);
    do_read(0, "R8 read back");
    do_write(0, 32'h1122_3344);              // repeat: mask must be zero (R3)
    do_write(0, 32'h0000_0080);
    for (int i = 0; i < 1024; i++) begin
      do_write(0, (32'h1 << (i % 32)) ^ W'(i * 32'h0103_0507));
      if (i % 16 == 0) do_write(1, 32'hC0DE_0000 | W'(i));
      if (i % 64 == 63) begin
        do_read(0, "R8 read back across migrations");
        do_read(1, "R5 other row intact");
      end
    end
    do_write(0, 32'hA5C3_0F96);
    chk(last_wdata == 32'hA5C3_0F96, "R7 offset wrapped to zero", last_wdata, 32'hA5C3_0F96);
    do_read(0, "R8 read after wrap");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule